// File: doc/BRIEF.md
# Port-Space Window Decoder

This block sits between a port-space access path and a set of device handlers. Each access carries a port number, a direction, a size of 1, 2 or 4 bytes and write data. Every device owns a fixed number of I/O windows. Each window has a programmed base and a fixed span, and a flag that says whether a handler is attached to it. The block compares the port against every window in the same cycle and picks one matching window. It then strobes that device's handler with the window index, the byte offset inside the window and the access fields.

The handler answers in the same cycle. The block registers that answer, so the response appears one clock after the access. A read that matches no window returns all ones. A handler's interrupt request is turned into the interrupt number assigned to the matched device. When no interrupt is raised, the interrupt output carries the 0xFF marker.

Top module: `iobar_decoder`

## Requirements
- R1: A window matches when the port lies between its base with bit 0 cleared (inclusive) and that masked base plus WIN_SIZE (exclusive). The comparison is made one bit wider than the port, so a window near the top of port space does not wrap.
- R2: A window whose live flag (`cfg_bar_live` bit w) is 0 never matches. Window w belongs to device w / NBAR and is window w % NBAR of that device.
- R3: When several windows match, the one with the highest index w = device*NBAR + window wins. `hnd_bar` then carries that window's index within its device.
- R4: `hnd_offset` equals the port minus the masked base of the winning window.
- R5: During an access that matches, `hnd_sel` has exactly the winning device's bit set in the same cycle, and `hnd_write`, `hnd_size` and `hnd_wdata` copy the access. `hnd_sel` is all zero when there is no access or no match.
- R6: `rsp_valid` is high in the cycle after a cycle with `acc_valid` high, and low after a cycle without one.
- R7: A read (`acc_write`=0) that matches no window returns `rsp_rdata` = 0xFFFFFFFF.
- R8: A read that matches returns the winning device's handler data with the unused lanes zeroed. Size code 1 keeps bits 7:0, code 2 keeps bits 15:0, and code 4 (or any other code) keeps all 32 bits.
- R9: `rsp_irq` is the winning device's 8-bit entry of `cfg_dev_irq` (device d at bits 8d+7:8d) when that device's `hnd_irq_req` bit was high during the access. Otherwise it is 0xFF, and it is always 0xFF on a miss.
- R10: A write returns `rsp_rdata` = 0, whether it matches or not.
- R11: While reset is held, `rsp_valid` is 0, `rsp_rdata` is 0 and `rsp_irq` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 3 | Byte count: 1, 2 or 4 |
| acc_port | input | PORT_W | Port number |
| acc_wdata | input | 32 | Write data |
| cfg_bar_base | input | NWIN*PORT_W | Window bases, window w at bits w*PORT_W |
| cfg_bar_live | input | NWIN | Handler-attached flag per window |
| cfg_dev_irq | input | NDEV*8 | Interrupt number per device |
| hnd_sel | output | NDEV | One-hot device strobe |
| hnd_bar | output | BAR_W | Window index within the device |
| hnd_offset | output | OFS_W | Offset inside the window |
| hnd_write | output | 1 | Direction to the handler |
| hnd_size | output | 3 | Size to the handler |
| hnd_wdata | output | 32 | Write data to the handler |
| hnd_rdata | input | NDEV*32 | Read data per device handler |
| hnd_irq_req | input | NDEV | Interrupt request per device handler |
| rsp_valid | output | 1 | Registered response present |
| rsp_hit | output | 1 | Registered response came from a handler |
| rsp_rdata | output | 32 | Registered read data |
| rsp_irq | output | 8 | Interrupt number or 0xFF |

## Verification
On every cycle, the assertions check these rules: the device strobe is one-hot or idle, a strobe points at a live window, the response follows one clock behind the access, misses never raise an interrupt, a read miss yields all ones, and a write yields zero. Other behaviours can only be shown by the bench's sweeps. These are the exact window edges, including a window that touches the top of port space, overlapping windows resolved toward the higher index, and dead windows hidden behind or exposing their neighbours. The sweeps also cover the offset arithmetic against an odd base, lane masking per size, and mapping each device's request to its own interrupt number.

// File: rtl/iobar_pkg.sv
package iobar_pkg;

   localparam int unsigned DATA_W = 32;
   localparam logic [7:0]  NO_IRQ = 8'hFF;

   typedef enum logic [2:0] {
      SZ_BYTE = 3'd1,
      SZ_HALF = 3'd2,
      SZ_WORD = 3'd4
   } acc_size_e;

   // lanes kept for a given byte count; unknown codes keep the full word
   function automatic logic [DATA_W-1:0] lane_mask(input logic [2:0] sz);
      case (sz)
         SZ_BYTE: lane_mask = 32'h0000_00FF;
         SZ_HALF: lane_mask = 32'h0000_FFFF;
         default: lane_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/iobar_window.sv
module iobar_window #(
   parameter int unsigned PORT_W   = 16,
   parameter int unsigned WIN_SIZE = 16,
   localparam int unsigned OFS_W   = (WIN_SIZE > 1) ? $clog2(WIN_SIZE) : 1,
   localparam int unsigned SPAN_W  = PORT_W + 1
) (
   input  logic [PORT_W-1:0] port_i,
   input  logic [PORT_W-1:0] base_i,
   input  logic              live_i,
   output logic              hit_o,
   output logic [OFS_W-1:0]  ofs_o
);

   logic [PORT_W-1:0] base_m;
   logic [SPAN_W-1:0] lo_ext;
   logic [SPAN_W-1:0] hi_ext;
   logic [SPAN_W-1:0] port_ext;

   assign base_m   = {base_i[PORT_W-1:1], 1'b0};
   assign lo_ext   = {1'b0, base_m};
   assign hi_ext   = lo_ext + SPAN_W'(WIN_SIZE);
   assign port_ext = {1'b0, port_i};

   assign hit_o = live_i && (port_ext >= lo_ext) && (port_ext < hi_ext);
   // exact on a hit since the distance is below WIN_SIZE <= 2**OFS_W
   assign ofs_o = port_i[OFS_W-1:0] - base_m[OFS_W-1:0];

endmodule

// File: rtl/iobar_scan.sv
module iobar_scan #(
   parameter int unsigned NWIN  = 8,
   parameter int unsigned OFS_W = 4,
   localparam int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic [NWIN-1:0]       hit_v,
   input  logic [NWIN*OFS_W-1:0] ofs_v,
   output logic                  any_o,
   output logic [IDX_W-1:0]      idx_o,
   output logic [OFS_W-1:0]      ofs_o
);

   // ascending walk, later hits overwrite earlier ones
   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      ofs_o = '0;
      for (int w = 0; w < int'(NWIN); w++) begin
         if (hit_v[w]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(w);
            ofs_o = ofs_v[w*OFS_W +: OFS_W];
         end
      end
   end

endmodule

// File: rtl/iobar_response.sv
module iobar_response
   import iobar_pkg::*;
#(
   parameter int unsigned NDEV  = 4,
   localparam int unsigned DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_valid,
   input  logic                   acc_write,
   input  logic [2:0]             acc_size,
   input  logic                   hit,
   input  logic [DEV_W-1:0]       dev,
   input  logic [NDEV*DATA_W-1:0] hnd_rdata,
   input  logic [NDEV-1:0]        hnd_irq_req,
   input  logic [NDEV*8-1:0]      cfg_dev_irq,
   output logic                   rsp_valid,
   output logic                   rsp_hit,
   output logic [DATA_W-1:0]      rsp_rdata,
   output logic [7:0]             rsp_irq
);

   logic [DATA_W-1:0] dev_data;
   logic [7:0]        dev_irq;
   logic              dev_req;
   logic [DATA_W-1:0] nxt_rdata;
   logic [7:0]        nxt_irq;

   always_comb begin
      dev_data = '0;
      dev_irq  = NO_IRQ;
      dev_req  = 1'b0;
      for (int d = 0; d < int'(NDEV); d++) begin
         if (dev == DEV_W'(d)) begin
            dev_data = hnd_rdata[d*DATA_W +: DATA_W];
            dev_irq  = cfg_dev_irq[d*8 +: 8];
            dev_req  = hnd_irq_req[d];
         end
      end
   end

   always_comb begin
      if (acc_write)  nxt_rdata = '0;
      else if (hit)   nxt_rdata = dev_data & lane_mask(acc_size);
      else            nxt_rdata = '1;
      nxt_irq = (hit && dev_req) ? dev_irq : NO_IRQ;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_rdata <= '0;
         rsp_irq   <= NO_IRQ;
      end else if (acc_valid) begin
         rsp_valid <= 1'b1;
         rsp_hit   <= hit;
         rsp_rdata <= nxt_rdata;
         rsp_irq   <= nxt_irq;
      end else begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_rdata <= '0;
         rsp_irq   <= NO_IRQ;
      end
   end

endmodule

// File: rtl/iobar_decoder.sv
module iobar_decoder
   import iobar_pkg::*;
#(
   parameter int unsigned NDEV     = 4,
   parameter int unsigned NBAR     = 2,
   parameter int unsigned PORT_W   = 16,
   parameter int unsigned WIN_SIZE = 16,
   localparam int unsigned NWIN    = NDEV * NBAR,
   localparam int unsigned DEV_W   = (NDEV > 1) ? $clog2(NDEV) : 1,
   localparam int unsigned BAR_W   = (NBAR > 1) ? $clog2(NBAR) : 1,
   localparam int unsigned IDX_W   = (NWIN > 1) ? $clog2(NWIN) : 1,
   localparam int unsigned OFS_W   = (WIN_SIZE > 1) ? $clog2(WIN_SIZE) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_valid,
   input  logic                     acc_write,
   input  logic [2:0]               acc_size,
   input  logic [PORT_W-1:0]        acc_port,
   input  logic [31:0]              acc_wdata,
   input  logic [NWIN*PORT_W-1:0]   cfg_bar_base,
   input  logic [NWIN-1:0]          cfg_bar_live,
   input  logic [NDEV*8-1:0]        cfg_dev_irq,
   output logic [NDEV-1:0]          hnd_sel,
   output logic [BAR_W-1:0]         hnd_bar,
   output logic [OFS_W-1:0]         hnd_offset,
   output logic                     hnd_write,
   output logic [2:0]               hnd_size,
   output logic [31:0]              hnd_wdata,
   input  logic [NDEV*32-1:0]       hnd_rdata,
   input  logic [NDEV-1:0]          hnd_irq_req,
   output logic                     rsp_valid,
   output logic                     rsp_hit,
   output logic [31:0]              rsp_rdata,
   output logic [7:0]               rsp_irq
);

   initial begin
      assert (NDEV >= 1) else $fatal(1, "NDEV must be at least 1");
      assert (NBAR >= 1) else $fatal(1, "NBAR must be at least 1");
      assert (WIN_SIZE >= 2) else $fatal(1, "WIN_SIZE must be at least 2");
      assert (PORT_W > OFS_W) else $fatal(1, "PORT_W too narrow for WIN_SIZE");
   end

   logic [NWIN-1:0]       win_hit;
   logic [NWIN*OFS_W-1:0] win_ofs;
   logic                  any_hit;
   logic [IDX_W-1:0]      win_idx;
   logic [OFS_W-1:0]      sel_ofs;
   logic [DEV_W-1:0]      win_dev;
   logic [BAR_W-1:0]      win_bar;
   logic                  strobe;

   for (genvar w = 0; w < int'(NWIN); w++) begin : g_win
      iobar_window #(
         .PORT_W  (PORT_W),
         .WIN_SIZE(WIN_SIZE)
      ) u_win (
         .port_i(acc_port),
         .base_i(cfg_bar_base[w*PORT_W +: PORT_W]),
         .live_i(cfg_bar_live[w]),
         .hit_o (win_hit[w]),
         .ofs_o (win_ofs[w*OFS_W +: OFS_W])
      );
   end

   iobar_scan #(
      .NWIN (NWIN),
      .OFS_W(OFS_W)
   ) u_scan (
      .hit_v(win_hit),
      .ofs_v(win_ofs),
      .any_o(any_hit),
      .idx_o(win_idx),
      .ofs_o(sel_ofs)
   );

   // split the flat window index into device and per-device window
   if (NBAR > 1 && (NBAR & (NBAR - 1)) == 0) begin : g_split_pow2
      assign win_dev = DEV_W'(win_idx >> BAR_W);
      assign win_bar = win_idx[BAR_W-1:0];
   end else begin : g_split_div
      assign win_dev = DEV_W'(win_idx / IDX_W'(NBAR));
      assign win_bar = BAR_W'(win_idx % IDX_W'(NBAR));
   end

   assign strobe = acc_valid && any_hit;

   always_comb begin
      hnd_sel = '0;
      for (int d = 0; d < int'(NDEV); d++)
         hnd_sel[d] = strobe && (win_dev == DEV_W'(d));
   end

   assign hnd_bar    = strobe ? win_bar : '0;
   assign hnd_offset = strobe ? sel_ofs : '0;
   assign hnd_write  = acc_write;
   assign hnd_size   = acc_size;
   assign hnd_wdata  = acc_wdata;

   iobar_response #(
      .NDEV(NDEV)
   ) u_rsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_write  (acc_write),
      .acc_size   (acc_size),
      .hit        (any_hit),
      .dev        (win_dev),
      .hnd_rdata  (hnd_rdata),
      .hnd_irq_req(hnd_irq_req),
      .cfg_dev_irq(cfg_dev_irq),
      .rsp_valid  (rsp_valid),
      .rsp_hit    (rsp_hit),
      .rsp_rdata  (rsp_rdata),
      .rsp_irq    (rsp_irq)
   );

   a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hnd_sel));

   a_r5_sel_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> hnd_sel == '0);

   a_r2_sel_live_only: assert property (@(posedge clk) disable iff (!rst_n)
      hnd_sel != '0 |-> cfg_bar_live[win_idx]);

   a_r6_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);

   a_r6_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid);

   a_r7_miss_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && hnd_sel == '0) |=> rsp_rdata == 32'hFFFF_FFFF);

   a_r9_miss_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && hnd_sel == '0) |=> rsp_irq == NO_IRQ);

   a_r10_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write) |=> rsp_rdata == '0);

endmodule

// File: tb/iobar_decoder_test.sv
module iobar_decoder_test;

   localparam int CLK_PERIOD = 10;
   localparam int NDEV = 4;
   localparam int NBAR = 2;
   localparam int NWIN = NDEV * NBAR;
   localparam int PORT_W = 16;
   localparam int WIN_SIZE = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0;
   logic acc_write = 1'b0;
   logic [2:0] acc_size = 3'd4;
   logic [15:0] acc_port = '0;
   logic [31:0] acc_wdata = '0;
   logic [NWIN*16-1:0] cfg_bar_base;
   logic [NWIN-1:0] cfg_bar_live;
   logic [NDEV*8-1:0] cfg_dev_irq;
   logic [NDEV-1:0] hnd_sel;
   logic [0:0] hnd_bar;
   logic [3:0] hnd_offset;
   logic hnd_write;
   logic [2:0] hnd_size;
   logic [31:0] hnd_wdata;
   logic [NDEV*32-1:0] hnd_rdata;
   logic [NDEV-1:0] hnd_irq_req;
   logic rsp_valid, rsp_hit;
   logic [31:0] rsp_rdata;
   logic [7:0] rsp_irq;

   logic [15:0] base_t [NWIN];
   logic [NWIN-1:0] live_t;
   logic [7:0] irq_t [NDEV];

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int w = 0; w < NWIN; w++) cfg_bar_base[w*16 +: 16] = base_t[w];
      for (int d = 0; d < NDEV; d++) cfg_dev_irq[d*8 +: 8] = irq_t[d];
      cfg_bar_live = live_t;
   end

   // handler model: data tags device, window and offset; odd offsets request an interrupt
   always_comb begin
      for (int d = 0; d < NDEV; d++) begin
         hnd_rdata[d*32 +: 32] = {4'hC, 4'(d), 7'd0, hnd_bar, 4'd0, hnd_offset, 8'h3C};
         hnd_irq_req[d] = hnd_sel[d] & hnd_offset[0];
      end
   end

   iobar_decoder #(
      .NDEV(NDEV), .NBAR(NBAR), .PORT_W(PORT_W), .WIN_SIZE(WIN_SIZE)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_size(acc_size),
      .acc_port(acc_port), .acc_wdata(acc_wdata),
      .cfg_bar_base(cfg_bar_base), .cfg_bar_live(cfg_bar_live), .cfg_dev_irq(cfg_dev_irq),
      .hnd_sel(hnd_sel), .hnd_bar(hnd_bar), .hnd_offset(hnd_offset),
      .hnd_write(hnd_write), .hnd_size(hnd_size), .hnd_wdata(hnd_wdata),
      .hnd_rdata(hnd_rdata), .hnd_irq_req(hnd_irq_req),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .rsp_irq(rsp_irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mask_of(input logic [2:0] sz);
      if (sz == 3'd1) return 32'h0000_00FF;
      if (sz == 3'd2) return 32'h0000_FFFF;
      return 32'hFFFF_FFFF;
   endfunction

   task automatic apply(input logic [15:0] port, input bit wr, input logic [2:0] sz, input logic [31:0] wd);
      int ew;
      int ed, eb;
      logic [16:0] lo;
      logic [15:0] eo;
      logic [31:0] erd;
      logic [7:0] eirq;
      ew = -1;
      eo = '0;
      for (int w = 0; w < NWIN; w++) begin
         lo = {1'b0, base_t[w] & 16'hFFFE};
         if (live_t[w] && {1'b0, port} >= lo && {1'b0, port} < lo + 17'(WIN_SIZE)) begin
            ew = w;
            eo = port - lo[15:0];
         end
      end
      ed = (ew >= 0) ? ew / NBAR : 0;
      eb = (ew >= 0) ? ew % NBAR : 0;
      @(negedge clk);
      acc_valid = 1'b1; acc_port = port; acc_write = wr; acc_size = sz; acc_wdata = wd;
      #1;
      check(hnd_sel == ((ew >= 0) ? 4'(1 << ed) : 4'd0), "R1 R2 R3 R5 sel", 32'(hnd_sel),
            (ew >= 0) ? 32'(1 << ed) : 32'd0);
      if (ew >= 0) begin
         check(hnd_bar == 1'(eb), "R3 bar", 32'(hnd_bar), 32'(eb));
         check(hnd_offset == eo[3:0], "R4 offset", 32'(hnd_offset), 32'(eo));
         check(hnd_write == wr && hnd_size == sz && hnd_wdata == wd, "R5 pass", hnd_wdata, wd);
      end
      if (wr) erd = 32'd0;                                           // R10
      else if (ew >= 0) erd = {4'hC, 4'(ed), 7'd0, 1'(eb), 4'd0, eo[3:0], 8'h3C} & mask_of(sz); // R8
      else erd = 32'hFFFF_FFFF;                                      // R7
      eirq = (ew >= 0 && eo[0]) ? irq_t[ed] : 8'hFF;                 // R9
      @(posedge clk);
      #1;
      check(rsp_valid == 1'b1, "R6 valid", 32'(rsp_valid), 32'd1);
      check(rsp_rdata == erd, wr ? "R10 wdata" : ((ew >= 0) ? "R8 rdata" : "R7 rdata"), rsp_rdata, erd);
      check(rsp_irq == eirq, "R9 irq", 32'(rsp_irq), 32'(eirq));
   endtask

   task automatic idle_check();
      @(negedge clk);
      acc_valid = 1'b0;
      @(posedge clk);
      #1;
      check(rsp_valid == 1'b0, "R6 idle", 32'(rsp_valid), 32'd0);
   endtask

   initial begin
      base_t[0] = 16'h0101; base_t[1] = 16'h0120; base_t[2] = 16'h0121; base_t[3] = 16'h0140;
      base_t[4] = 16'h0148; base_t[5] = 16'h0161; base_t[6] = 16'h0108; base_t[7] = 16'hFFF8;
      live_t = 8'b1111_1101;
      irq_t[0] = 8'd3; irq_t[1] = 8'd5; irq_t[2] = 8'd6; irq_t[3] = 8'd7;

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R11 valid", 32'(rsp_valid), 32'd0);
      check(rsp_rdata == 32'd0, "R11 rdata", rsp_rdata, 32'd0);
      check(rsp_irq == 8'hFF, "R11 irq", 32'(rsp_irq), 32'hFF);
      rst_n = 1'b1;

      // overlapping, dead and odd-based windows, all sizes, some writes
      for (int p = 16'h00F0; p < 16'h0180; p++) begin
         apply(16'(p), (p % 5) == 0, (p % 3 == 0) ? 3'd1 : ((p % 3 == 1) ? 3'd2 : 3'd4),
               32'hDEAD_0000 | 32'(p));
      end
      idle_check();
      // window touching the top of port space
      for (int p = 16'hFFE8; p <= 16'hFFFF; p++) begin
         apply(16'(p), 1'b0, 3'd4, 32'd0);
      end
      idle_check();
      // remove the overlapping winners: earlier windows become visible
      live_t[4] = 1'b0;
      live_t[6] = 1'b0;
      for (int p = 16'h0100; p < 16'h0160; p++) begin
         apply(16'(p), 1'b0, 3'd4, 32'd0);
      end
      idle_check();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule